// File: doc/BRIEF.md
# Condition Code Flag Register

This block keeps the eight-bit status byte of a small eight-bit processor core. Each cycle the core presents an instruction-class code with the ALU result, carry-out and carry from bit 3 into bit 4. The block then updates the half-carry, negative, zero and carry flags that the class allows, and leaves the other flags as they are. Separate commands force the carry flag, and other commands change the two-bit interrupt priority field. A whole-byte write restores the register after a stack pop.

The interrupt priority is kept in bits 5 and 3 of the byte. Its level encoding is not binary, and the pattern with both bits set masks interrupts. The block registers the decoded level and a mask indication for the interrupt logic. A combinational branch-condition output tests one flag, selected by a three-bit code, against the flags currently held.

Top module: `ccr_flag_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the byte becomes 8'hE8 after that edge. The priority bits are both 1, H, N, Z and C are 0, `prio_level_o` is 3 and `irq_masked_o` is 1.
- R2: Bits 7 and 6 of `ccr_o` always read 1. A pop write cannot clear them.
- R3: H (bit 4) takes `alu_half_i` only when the class is add (code 1). For every other class code, H keeps its value.
- R4: For the add (1), arithmetic (2) and logic (3) classes, N (bit 2) becomes bit 7 of the result and Z (bit 1) becomes 1 exactly when the result is zero. For the bit-test class (4) and the unused codes (0, 5-7), N and Z keep their values.
- R5: For the add, arithmetic and bit-test classes, C (bit 0) takes `alu_carry_i`. For the logic class and the unused codes, C keeps its value.
- R6: `carry_cmd_i` = 1 sets C and `carry_cmd_i` = 2 clears C. Either command overrides any class update of C in the same cycle. Codes 0 and 3 leave C to the class.
- R7: {I1,I0} = {bit 5, bit 3} encodes the priority levels as follows: 10 is level 0, 01 is level 1, 00 is level 2 and 11 is level 3. `prio_level_o` gives the level in binary, and `irq_masked_o` is 1 exactly at level 3. Both outputs follow the priority bits with no lag.
- R8: `prio_cmd_i` = 1 loads {I1,I0} from `prio_in_i[1:0]`, `prio_cmd_i` = 2 writes 10 (level 0), and `prio_cmd_i` = 3 writes 11 (level 3). Code 0 leaves the priority bits unchanged.
- R9: When `pop_we_i` is high, bits 5..0 take `pop_data_i[5:0]` at the next edge. Any class, carry or priority update requested in the same cycle is ignored.
- R10: The value of `cond_true_o` is set by `cond_sel_i` with no clock delay, as follows: 0 gives C, 1 gives !C, 2 gives Z, 3 gives !Z, 4 gives N, 5 gives !N, 6 gives H and 7 gives !H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| flag_class_i | input | 3 | Instruction class of the current ALU result |
| alu_res_i | input | 8 | ALU result byte |
| alu_carry_i | input | 1 | ALU carry or borrow out |
| alu_half_i | input | 1 | ALU carry from bit 3 into bit 4 |
| carry_cmd_i | input | 2 | Carry force command |
| prio_cmd_i | input | 2 | Priority field command |
| prio_in_i | input | 2 | Priority bits {I1,I0} for interrupt entry |
| pop_we_i | input | 1 | Whole-byte restore strobe |
| pop_data_i | input | 8 | Byte restored from the stack |
| cond_sel_i | input | 3 | Branch condition select |
| ccr_o | output | 8 | Current condition code byte |
| prio_level_o | output | 2 | Current priority level, binary |
| irq_masked_o | output | 1 | High when the level is 3 |
| cond_true_o | output | 1 | Selected branch condition result |

## Verification
The main same-cycle clashes are a pop restore against a flag update and a priority command, and a carry force command against an arithmetic class that also writes C. Random stimulus raises every strobe on its own schedule, so these clashes occur often. Directed cycles also pair a pop with an add class and with a priority-enter command, and pair carry clear with an add whose carry-out is set. A behavioural model applies the precedence rules, and each flag field is compared with the model after every edge.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

  localparam int unsigned CCR_W    = 8;
  localparam int unsigned LOW_W    = 6;
  localparam int unsigned BIT_C    = 0;
  localparam int unsigned BIT_Z    = 1;
  localparam int unsigned BIT_N    = 2;
  localparam int unsigned BIT_I0   = 3;
  localparam int unsigned BIT_H    = 4;
  localparam int unsigned BIT_I1   = 5;

  typedef enum logic [2:0] {
    CLS_NONE    = 3'd0,
    CLS_ADD     = 3'd1,
    CLS_ARITH   = 3'd2,
    CLS_LOGIC   = 3'd3,
    CLS_BITTEST = 3'd4
  } flag_class_e;

  typedef enum logic [1:0] {
    CC_KEEP = 2'd0,
    CC_SET  = 2'd1,
    CC_CLR  = 2'd2
  } carry_cmd_e;

  typedef enum logic [1:0] {
    PC_NONE    = 2'd0,
    PC_ENTER   = 2'd1,
    PC_ENABLE  = 2'd2,
    PC_DISABLE = 2'd3
  } prio_cmd_e;

  // {I1,I0} raw patterns
  localparam logic [1:0] PRIO_MAIN = 2'b10;
  localparam logic [1:0] PRIO_OFF  = 2'b11;

  typedef struct packed {
    logic h;
    logic n;
    logic z;
    logic c;
  } arith_flags_t;

endpackage

// File: rtl/ccr_arith_flags.sv
module ccr_arith_flags
  import ccr_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [2:0]        class_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic              carry_i,
  input  logic              half_i,
  input  logic [1:0]        carry_cmd_i,
  input  arith_flags_t      cur_i,
  output arith_flags_t      nxt_o
);
  localparam int unsigned MSB = DATA_W - 1;

  flag_class_e cls;
  carry_cmd_e  ccmd;
  logic        is_zero;
  logic        wr_nz;
  logic        wr_c;
  arith_flags_t by_class;

  assign cls     = flag_class_e'(class_i);
  assign ccmd    = carry_cmd_e'(carry_cmd_i);
  assign is_zero = (res_i == '0);

  always_comb begin
    wr_nz = 1'b0;
    wr_c  = 1'b0;
    unique case (cls)
      CLS_ADD:     begin wr_nz = 1'b1; wr_c = 1'b1; end
      CLS_ARITH:   begin wr_nz = 1'b1; wr_c = 1'b1; end
      CLS_LOGIC:   wr_nz = 1'b1;
      CLS_BITTEST: wr_c  = 1'b1;
      default:     ;
    endcase
  end

  always_comb begin
    by_class   = cur_i;
    if (cls == CLS_ADD) by_class.h = half_i;
    if (wr_nz) begin
      by_class.n = res_i[MSB];
      by_class.z = is_zero;
    end
    if (wr_c) by_class.c = carry_i;
  end

  always_comb begin
    nxt_o = by_class;
    if (ccmd == CC_SET)      nxt_o.c = 1'b1;
    else if (ccmd == CC_CLR) nxt_o.c = 1'b0;
  end

endmodule

// File: rtl/ccr_prio_field.sv
module ccr_prio_field
  import ccr_pkg::*;
(
  input  logic [1:0] cmd_i,
  input  logic [1:0] prio_in_i,
  input  logic [1:0] cur_i,
  output logic [1:0] nxt_o,
  output logic [1:0] level_o
);
  prio_cmd_e cmd;
  assign cmd = prio_cmd_e'(cmd_i);

  always_comb begin
    unique case (cmd)
      PC_ENTER:   nxt_o = prio_in_i;
      PC_ENABLE:  nxt_o = PRIO_MAIN;
      PC_DISABLE: nxt_o = PRIO_OFF;
      default:    nxt_o = cur_i;
    endcase
  end

  // binary level of an arbitrary {I1,I0} pattern (used on the next-state bits)
  assign level_o = {~(cur_i[1] ^ cur_i[0]), cur_i[0]};

endmodule

// File: rtl/ccr_branch_eval.sv
module ccr_branch_eval
  import ccr_pkg::*;
(
  input  logic [2:0]   sel_i,
  input  arith_flags_t flags_i,
  output logic         true_o
);
  logic [3:0] pick;
  assign pick = {flags_i.h, flags_i.n, flags_i.z, flags_i.c};
  assign true_o = pick[sel_i[2:1]] ^ sel_i[0];
endmodule

// File: rtl/ccr_flag_unit.sv
module ccr_flag_unit
  import ccr_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        flag_class_i,
  input  logic [DATA_W-1:0] alu_res_i,
  input  logic              alu_carry_i,
  input  logic              alu_half_i,
  input  logic [1:0]        carry_cmd_i,
  input  logic [1:0]        prio_cmd_i,
  input  logic [1:0]        prio_in_i,
  input  logic              pop_we_i,
  input  logic [CCR_W-1:0]  pop_data_i,
  input  logic [2:0]        cond_sel_i,
  output logic [CCR_W-1:0]  ccr_o,
  output logic [1:0]        prio_level_o,
  output logic              irq_masked_o,
  output logic              cond_true_o
);
  localparam logic [LOW_W-1:0] LOW_RST = 6'b101000;

  logic [LOW_W-1:0] low_q, low_d;
  logic [1:0]       lvl_q;
  logic [1:0]       lvl_d;
  logic             msk_q;
  arith_flags_t     cur_f, nxt_f;
  logic [1:0]       cur_p, nxt_p, nxt_lvl;

  assign cur_f = '{h: low_q[BIT_H], n: low_q[BIT_N], z: low_q[BIT_Z], c: low_q[BIT_C]};
  assign cur_p = {low_q[BIT_I1], low_q[BIT_I0]};

  ccr_arith_flags #(.DATA_W(DATA_W)) arith_i (
    .class_i     (flag_class_i),
    .res_i       (alu_res_i),
    .carry_i     (alu_carry_i),
    .half_i      (alu_half_i),
    .carry_cmd_i (carry_cmd_i),
    .cur_i       (cur_f),
    .nxt_o       (nxt_f)
  );

  ccr_prio_field prio_i (
    .cmd_i     (prio_cmd_i),
    .prio_in_i (prio_in_i),
    .cur_i     (cur_p),
    .nxt_o     (nxt_p),
    .level_o   ()
  );

  ccr_prio_field lvl_dec_i (
    .cmd_i     (2'd0),
    .prio_in_i (2'd0),
    .cur_i     (low_d[BIT_I1] ? {1'b1, low_d[BIT_I0]} : {1'b0, low_d[BIT_I0]}),
    .nxt_o     (),
    .level_o   (nxt_lvl)
  );

  always_comb begin
    if (pop_we_i) begin
      low_d = pop_data_i[LOW_W-1:0];
    end else begin
      low_d          = '0;
      low_d[BIT_I1]  = nxt_p[1];
      low_d[BIT_H]   = nxt_f.h;
      low_d[BIT_I0]  = nxt_p[0];
      low_d[BIT_N]   = nxt_f.n;
      low_d[BIT_Z]   = nxt_f.z;
      low_d[BIT_C]   = nxt_f.c;
    end
  end

  assign lvl_d = nxt_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_q <= LOW_RST;
      lvl_q <= 2'd3;
      msk_q <= 1'b1;
    end else begin
      low_q <= low_d;
      lvl_q <= lvl_d;
      msk_q <= (lvl_d == 2'd3);
    end
  end

  assign ccr_o        = {2'b11, low_q};
  assign prio_level_o = lvl_q;
  assign irq_masked_o = msk_q;

  ccr_branch_eval br_i (
    .sel_i   (cond_sel_i),
    .flags_i (cur_f),
    .true_o  (cond_true_o)
  );

  AST_RESET_VALUE: assert property (@(posedge clk) rst |=> (ccr_o == 8'hE8 && prio_level_o == 2'd3)); // R1
  AST_H_HELD: assert property (@(posedge clk) disable iff (rst)
    (!pop_we_i && flag_class_i != CLS_ADD) |=> $stable(ccr_o[BIT_H])); // R3
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
    (!pop_we_i && (flag_class_i == CLS_ADD || flag_class_i == CLS_ARITH || flag_class_i == CLS_LOGIC))
    |=> ccr_o[BIT_Z] == ($past(alu_res_i) == '0)); // R4
  AST_CARRY_FORCE: assert property (@(posedge clk) disable iff (rst)
    (!pop_we_i && carry_cmd_i == CC_SET) |=> ccr_o[BIT_C]); // R6
  AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (rst)
    (irq_masked_o == (ccr_o[BIT_I1] & ccr_o[BIT_I0])) && (prio_level_o[0] == ccr_o[BIT_I0])); // R7
  AST_PRIO_ENTER: assert property (@(posedge clk) disable iff (rst)
    (!pop_we_i && prio_cmd_i == PC_ENTER)
    |=> {ccr_o[BIT_I1], ccr_o[BIT_I0]} == $past(prio_in_i)); // R8
  AST_POP_WINS: assert property (@(posedge clk) disable iff (rst)
    pop_we_i |=> ccr_o[LOW_W-1:0] == $past(pop_data_i[LOW_W-1:0])); // R9

endmodule

// File: tb/ccr_flag_unit_tb_top.sv
module ccr_flag_unit_tb_top;
  localparam real CLK_NS = 4.0;

  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] flag_class_i;
  logic [7:0] alu_res_i;
  logic       alu_carry_i, alu_half_i;
  logic [1:0] carry_cmd_i, prio_cmd_i, prio_in_i;
  logic       pop_we_i;
  logic [7:0] pop_data_i;
  logic [2:0] cond_sel_i;
  logic [7:0] ccr_o;
  logic [1:0] prio_level_o;
  logic       irq_masked_o, cond_true_o;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  // model state
  bit m_h, m_n, m_z, m_c, m_i1, m_i0;

  always #(CLK_NS/2) clk = ~clk;

  ccr_flag_unit dut_i (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int m_level();
    case ({m_i1, m_i0})
      2'b10: return 0;
      2'b01: return 1;
      2'b00: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic bit m_cond(input int sel);
    bit f;
    case (sel / 2)
      0: f = m_c;
      1: f = m_z;
      2: f = m_n;
      default: f = m_h;
    endcase
    return (sel % 2) ? !f : f;
  endfunction

  task automatic model_step();
    if (pop_we_i) begin
      m_i1 = pop_data_i[5]; m_h = pop_data_i[4]; m_i0 = pop_data_i[3];
      m_n = pop_data_i[2]; m_z = pop_data_i[1]; m_c = pop_data_i[0];
      return;
    end
    case (flag_class_i)
      3'd1: begin m_h = alu_half_i; m_n = alu_res_i[7]; m_z = (alu_res_i == 0); m_c = alu_carry_i; end
      3'd2: begin m_n = alu_res_i[7]; m_z = (alu_res_i == 0); m_c = alu_carry_i; end
      3'd3: begin m_n = alu_res_i[7]; m_z = (alu_res_i == 0); end
      3'd4: m_c = alu_carry_i;
      default: ;
    endcase
    if (carry_cmd_i == 2'd1) m_c = 1;
    if (carry_cmd_i == 2'd2) m_c = 0;
    case (prio_cmd_i)
      2'd1: {m_i1, m_i0} = prio_in_i;
      2'd2: {m_i1, m_i0} = 2'b10;
      2'd3: {m_i1, m_i0} = 2'b11;
      default: ;
    endcase
  endtask

  task automatic compare_all();
    chk("R2 top bits", ccr_o[7:6], 2'b11);
    chk("R3/R9 H", ccr_o[4], m_h);
    chk("R4/R9 N", ccr_o[2], m_n);
    chk("R4/R9 Z", ccr_o[1], m_z);
    chk("R5/R6/R9 C", ccr_o[0], m_c);
    chk("R8/R9 I1I0", {ccr_o[5], ccr_o[3]}, {m_i1, m_i0});
    chk("R7 level", prio_level_o, m_level());
    chk("R7 masked", irq_masked_o, m_level() == 3);
  endtask

  // inputs already driven (at negedge); check cond, clock, check state
  task automatic step();
    #0.5;
    chk("R10 cond", cond_true_o, m_cond(cond_sel_i));
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle_inputs();
    flag_class_i = 0; alu_res_i = 0; alu_carry_i = 0; alu_half_i = 0;
    carry_cmd_i = 0; prio_cmd_i = 0; prio_in_i = 0; pop_we_i = 0;
    pop_data_i = 0; cond_sel_i = 0;
  endtask

  initial begin
    idle_inputs();
    rst = 1;
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk("R1 reset byte", ccr_o, 8'hE8);
    chk("R1 reset level", prio_level_o, 3);
    chk("R1 reset masked", irq_masked_o, 1);
    rst = 0;
    m_h = 0; m_n = 0; m_z = 0; m_c = 0; m_i1 = 1; m_i0 = 1;

    // R3 add writes H, R4 zero result
    flag_class_i = 1; alu_res_i = 8'h00; alu_half_i = 1; alu_carry_i = 1; step();
    // R3 logic leaves H
    flag_class_i = 3; alu_res_i = 8'h80; alu_half_i = 0; alu_carry_i = 0; step();
    // R6 clear overrides add carry
    flag_class_i = 1; alu_res_i = 8'h12; alu_carry_i = 1; carry_cmd_i = 2; step();
    carry_cmd_i = 0;
    // R9 pop beats add and priority enter, tries to clear bits 7:6
    flag_class_i = 1; alu_res_i = 8'hFF; alu_carry_i = 1; alu_half_i = 1;
    prio_cmd_i = 1; prio_in_i = 2'b00; pop_we_i = 1; pop_data_i = 8'h08; step();
    pop_we_i = 0; prio_cmd_i = 0; flag_class_i = 0;
    // R8 enable, enter each pattern, disable
    prio_cmd_i = 2; step();
    for (int p = 0; p < 4; p++) begin prio_cmd_i = 1; prio_in_i = p[1:0]; step(); end
    prio_cmd_i = 3; step();
    prio_cmd_i = 0;
    // R10 all selects
    for (int s = 0; s < 8; s++) begin cond_sel_i = s[2:0]; step(); end

    // random collisions
    for (int i = 0; i < 3000; i++) begin
      flag_class_i = $urandom_range(0, 7);
      alu_res_i    = ($urandom_range(0, 3) == 0) ? 8'h00 : 8'($urandom);
      alu_carry_i  = $urandom_range(0, 1);
      alu_half_i   = $urandom_range(0, 1);
      carry_cmd_i  = $urandom_range(0, 3);
      prio_cmd_i   = $urandom_range(0, 3);
      prio_in_i    = $urandom_range(0, 3);
      pop_we_i     = ($urandom_range(0, 5) == 0);
      pop_data_i   = 8'($urandom);
      cond_sel_i   = $urandom_range(0, 7);
      step();
    end

    // reset mid-run: R1
    idle_inputs();
    rst = 1; @(negedge clk); @(negedge clk);
    chk("R1 second reset", ccr_o, 8'hE8);
    rst = 0;

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      done = 1;
      checks++; errs++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule